// File: doc/BRIEF.md
# Packed Per-Channel DMA Interrupt Controller

This block gathers the completion events of a bank of DMA channels into one interrupt line. Each channel raises single-cycle pulses for three event kinds: half of a transfer done, one descriptor done, and the whole descriptor chain done. Every pulse sets a sticky status bit. A matching enable bit decides whether that status bit can raise the interrupt. Software reads the status words, services the channels, and writes the same value back to clear exactly the bits it has handled.

Each channel's bits sit in a 4-bit group. Eight groups fill one 32-bit word, so sixteen channels need two enable words and two status words. A read-only word reports which channels are busy. The address decoder claims only these words. For the per-channel register windows above them, it reports that the access belongs to a channel and gives that channel's index.

The register port is a plain strobe interface. An access takes effect on the clock edge where `bus_req` is high. The port never stalls, so it has no back-pressure. Read data comes back on the following cycle, marked by `rd_valid`.

Top module: `dma_irq_hub`

## Requirements
- R1: A pulse on `evt_half[n]`, `evt_pkg[n]` or `evt_chain[n]` sets status bit 0, 1 or 2 of channel n's group, whatever its enable bit holds. Channel n's group is in the status word at offset 0x10 + 4·(n/8), at bits 4·(n mod 8) upward.
- R2: The enable words at offsets 0x00 and 0x04 use the same group layout and are read/write. Group bit 3 is not stored and always reads 0.
- R3: Writing a status word clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends set.
- R5: `irq` is a register that is high exactly one cycle after any bit is both pending and enabled. It falls one cycle after the last such pair goes away, whether by clearing the status bit or by disabling it.
- R6: The word at offset 0x30 reads bit n = `chan_busy[n]`, with bits 31:16 reading 0. Writes to it have no effect.
- R7: A read returns its data with `rd_valid` high in the cycle after the request. Unmapped offsets below 0x100 read 0. Writes to unmapped offsets change nothing.
- R8: `own_hit` is high only for offsets 0x00, 0x04, 0x10, 0x14 and 0x30. For offsets 0x100 + 0x40·n up to 0x13F + 0x40·n with n < 16, `route_hit` is high and `route_idx` = n, and `own_hit` is low.
- R9: After reset all enable bits and status bits are 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access strobe, taken on the clock edge |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| own_hit | output | 1 | Address decodes to a register of this block |
| route_hit | output | 1 | Address decodes to a per-channel window |
| route_idx | output | 4 | Channel owning the decoded window |
| evt_half | input | 16 | Half-transfer event pulse per channel |
| evt_pkg | input | 16 | Descriptor-done event pulse per channel |
| evt_chain | input | 16 | Chain-done event pulse per channel |
| chan_busy | input | 16 | Busy level per channel |
| irq | output | 1 | Combined, registered interrupt |

## Verification
On every cycle, the assertions check these behaviours:
- the one-cycle link between pending-and-enabled bits and `irq`, in both directions;
- that a channel-0 event is always latched one cycle later, including when a clear hits the same cycle;
- the read-valid timing;
- that the two address claims never overlap;
- the zero upper half of the busy word.

Only the bench scenarios can show the rest:
- the exact group placement of each event kind across both register words;
- partial write-one-to-clear masks;
- enable read-back with bit 3 dropped;
- that writes to the read-only and unmapped words leave state untouched;
- the decoded channel index for a window.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int REG_W     = 32;
  localparam int NIB_W     = 4;
  localparam int EVT_KINDS = 3;
  localparam int CH_PER_REG = REG_W / NIB_W;

  typedef enum logic [1:0] {
    EV_HALF  = 2'd0,
    EV_PKG   = 2'd1,
    EV_CHAIN = 2'd2
  } evt_kind_e;

  // Mask keeping the low EVT_KINDS bits of each 4-bit group
  function automatic logic [REG_W-1:0] group_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int g = 0; g < CH_PER_REG; g++) begin
      for (int k = 0; k < EVT_KINDS; k++) begin
        m[g*NIB_W + k] = 1'b1;
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/dma_irq_decode.sv
module dma_irq_decode #(
  parameter int ADDR_W    = 12,
  parameter int NUM_REGS  = 2,
  parameter int NUM_CH    = 16,
  parameter int EN_BASE   = 'h00,
  parameter int ST_BASE   = 'h10,
  parameter int GLB_OFS   = 'h30,
  parameter int CH_BASE   = 'h100,
  parameter int CH_STRIDE = 'h40,
  localparam int IDX_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_REGS-1:0] sel_en,
  output logic [NUM_REGS-1:0] sel_st,
  output logic                sel_glob,
  output logic                own_hit,
  output logic                route_hit,
  output logic [IDX_W-1:0]    route_idx
);
  localparam int STRIDE_SH = $clog2(CH_STRIDE);
  localparam int CH_END    = CH_BASE + NUM_CH * CH_STRIDE;

  logic [31:0] a32;
  logic [31:0] off;

  assign a32 = 32'(addr);
  assign off = a32 - 32'(CH_BASE);

  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) begin
      sel_en[r] = (a32 == 32'(EN_BASE + 4*r));
      sel_st[r] = (a32 == 32'(ST_BASE + 4*r));
    end
    sel_glob  = (a32 == 32'(GLB_OFS));
    own_hit   = (|sel_en) | (|sel_st) | sel_glob;
    route_hit = (a32 >= 32'(CH_BASE)) && (a32 < 32'(CH_END));
    route_idx = route_hit ? IDX_W'(off >> STRIDE_SH) : '0;
  end
endmodule

// File: rtl/dma_irq_bank.sv
module dma_irq_bank
  import dma_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] evt_word,
  input  logic             en_we,
  input  logic             st_we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] en_q,
  output logic [REG_W-1:0] st_q
);
  localparam logic [REG_W-1:0] USED = group_mask();

  logic [REG_W-1:0] clr;
  logic [REG_W-1:0] st_d;

  always_comb begin
    clr  = st_we ? wdata : '0;
    // event wins over a same-cycle clear
    st_d = ((st_q & ~clr) | evt_word) & USED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      if (en_we) en_q <= wdata & USED;
      st_q <= st_d;
    end
  end
endmodule

// File: rtl/dma_irq_rdmux.sv
module dma_irq_rdmux
  import dma_irq_pkg::*;
#(
  parameter int NUM_REGS = 2,
  parameter int NUM_CH   = 16
) (
  input  logic [NUM_REGS-1:0]       sel_en,
  input  logic [NUM_REGS-1:0]       sel_st,
  input  logic                      sel_glob,
  input  logic [NUM_REGS*REG_W-1:0] en_all,
  input  logic [NUM_REGS*REG_W-1:0] st_all,
  input  logic [NUM_CH-1:0]         busy,
  output logic [REG_W-1:0]          rdata
);
  always_comb begin
    rdata = sel_glob ? REG_W'(busy) : '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (sel_en[r]) rdata = rdata | en_all[r*REG_W +: REG_W];
      if (sel_st[r]) rdata = rdata | st_all[r*REG_W +: REG_W];
    end
  end
endmodule

// File: rtl/dma_irq_hub.sv
module dma_irq_hub
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 12,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic              rd_valid,
  output logic [REG_W-1:0]  rd_data,
  output logic              own_hit,
  output logic              route_hit,
  output logic [IDX_W-1:0]  route_idx,
  input  logic [NUM_CH-1:0] evt_half,
  input  logic [NUM_CH-1:0] evt_pkg,
  input  logic [NUM_CH-1:0] evt_chain,
  input  logic [NUM_CH-1:0] chan_busy,
  output logic              irq
);
  localparam int NUM_REGS = (NUM_CH + CH_PER_REG - 1) / CH_PER_REG;
  localparam int SLOTS    = NUM_REGS * CH_PER_REG;
  localparam int FLAT_W   = NUM_REGS * REG_W;

  logic [NUM_REGS-1:0] sel_en, sel_st;
  logic                sel_glob;
  logic [FLAT_W-1:0]   evt_flat, en_all, st_all;
  logic [REG_W-1:0]    rdata;
  logic                wr_acc, rd_acc;

  assign wr_acc = bus_req & bus_write;
  assign rd_acc = bus_req & ~bus_write;

  dma_irq_decode #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .NUM_CH(NUM_CH)
  ) u_dec (
    .addr(bus_addr), .sel_en(sel_en), .sel_st(sel_st), .sel_glob(sel_glob),
    .own_hit(own_hit), .route_hit(route_hit), .route_idx(route_idx)
  );

  // place each channel's three events in its 4-bit group
  for (genvar c = 0; c < SLOTS; c++) begin : g_slot
    if (c < NUM_CH) begin : g_live
      assign evt_flat[c*NIB_W + 0] = evt_half[c];
      assign evt_flat[c*NIB_W + 1] = evt_pkg[c];
      assign evt_flat[c*NIB_W + 2] = evt_chain[c];
    end else begin : g_pad
      assign evt_flat[c*NIB_W +: EVT_KINDS] = '0;
    end
    assign evt_flat[c*NIB_W + 3] = 1'b0;
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_bank
    dma_irq_bank u_bank (
      .clk(clk), .rst_n(rst_n),
      .evt_word(evt_flat[r*REG_W +: REG_W]),
      .en_we(wr_acc & sel_en[r]),
      .st_we(wr_acc & sel_st[r]),
      .wdata(bus_wdata),
      .en_q(en_all[r*REG_W +: REG_W]),
      .st_q(st_all[r*REG_W +: REG_W])
    );
  end

  dma_irq_rdmux #(.NUM_REGS(NUM_REGS), .NUM_CH(NUM_CH)) u_rd (
    .sel_en(sel_en), .sel_st(sel_st), .sel_glob(sel_glob),
    .en_all(en_all), .st_all(st_all), .busy(chan_busy), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      irq      <= 1'b0;
    end else begin
      rd_valid <= rd_acc;
      if (rd_acc) rd_data <= rdata;
      irq <= |(st_all & en_all);
    end
  end
endmodule

// File: rtl/dma_irq_chk.sv
module dma_irq_chk #(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 12,
  parameter int FLAT_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              rd_valid,
  input logic [31:0]       rd_data,
  input logic              own_hit,
  input logic              route_hit,
  input logic [NUM_CH-1:0] evt_half,
  input logic [NUM_CH-1:0] evt_chain,
  input logic              irq,
  input logic [FLAT_W-1:0] st_all,
  input logic [FLAT_W-1:0] en_all
);
  p_half_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_half[0] |=> st_all[0]);

  p_chain_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_chain[0] |=> st_all[2]);

  p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(st_all & en_all)) |=> irq);

  p_irq_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(st_all & en_all)) |=> !irq);

  p_busy_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_write && bus_addr == ADDR_W'('h30)) |=> ((rd_data >> NUM_CH) == 0));

  p_rd_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_write) |=> rd_valid);

  p_rd_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_write) |=> !rd_valid);

  p_claim_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(own_hit && route_hit));
endmodule

bind dma_irq_hub dma_irq_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .FLAT_W(FLAT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_write(bus_write),
  .bus_addr(bus_addr), .rd_valid(rd_valid), .rd_data(rd_data),
  .own_hit(own_hit), .route_hit(route_hit), .evt_half(evt_half),
  .evt_chain(evt_chain), .irq(irq), .st_all(st_all), .en_all(en_all)
);

// File: tb/dma_irq_hub_test.sv
`timescale 1ns/1ps
module dma_irq_hub_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rd_valid, own_hit, route_hit, irq;
  logic [31:0] rd_data;
  logic [3:0]  route_idx;
  logic [15:0] evt_half = '0, evt_pkg = '0, evt_chain = '0, chan_busy = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dma_irq_hub uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .own_hit(own_hit), .route_hit(route_hit),
    .route_idx(route_idx), .evt_half(evt_half), .evt_pkg(evt_pkg),
    .evt_chain(evt_chain), .chan_busy(chan_busy), .irq(irq)
  );

  // {channel[3:0], kind[1:0], enabled}
  localparam logic [6:0] VEC [8] = '{
    {4'd0,  2'd0, 1'b1}, {4'd7,  2'd2, 1'b0}, {4'd8, 2'd1, 1'b1},
    {4'd15, 2'd2, 1'b1}, {4'd3,  2'd1, 1'b0}, {4'd12, 2'd0, 1'b1},
    {4'd9,  2'd2, 1'b0}, {4'd5,  2'd2, 1'b1}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    chk(32'(rd_valid), 32'd1, "R7 rd_valid");
    d = rd_data;
  endtask

  task automatic pulse(input int ch, input int kind);
    @(negedge clk);
    case (kind)
      0: evt_half[ch] = 1'b1;
      1: evt_pkg[ch] = 1'b1;
      default: evt_chain[ch] = 1'b1;
    endcase
    @(negedge clk);
    evt_half = '0; evt_pkg = '0; evt_chain = '0;
  endtask

  task automatic clear_all();
    wr(12'h000, 32'h0); wr(12'h004, 32'h0);
    wr(12'h010, 32'hFFFF_FFFF); wr(12'h014, 32'hFFFF_FFFF);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk(32'(irq), 0, "R9 irq after reset");
    rd(12'h000, d); chk(d, 0, "R9 enable0 after reset");
    rd(12'h014, d); chk(d, 0, "R9 status1 after reset");

    // table-driven: R1 placement, R5 irq follows enable
    for (int i = 0; i < 8; i++) begin
      int ch, kind, bitpos;
      logic en_on;
      logic [11:0] ra;
      ch = int'(VEC[i][6:3]); kind = int'(VEC[i][2:1]); en_on = VEC[i][0];
      bitpos = 4 * (ch % 8) + kind;
      ra = (ch < 8) ? 12'h000 : 12'h004;
      clear_all();
      wr(ra, en_on ? (32'h1 << bitpos) : 32'h0);
      pulse(ch, kind);
      @(negedge clk);
      chk(32'(irq), 32'(en_on), "R5 irq per vector");
      rd(ra + 12'h010, d);
      chk(d, 32'h1 << bitpos, "R1 status placement");
    end

    // R2 enable read-back drops group bit 3
    clear_all();
    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h004, d); chk(d, 32'h7777_7777, "R2 enable mask");
    wr(12'h004, 32'h0);

    // R3 partial write-one-to-clear
    pulse(2, 0); pulse(2, 1); pulse(10, 2);
    wr(12'h010, 32'h0000_0100);
    rd(12'h010, d); chk(d, 32'h0000_0200, "R3 partial clear");
    rd(12'h014, d); chk(d, 32'h0000_0400, "R3 other word untouched");

    // R4 event and clear in the same cycle
    clear_all();
    pulse(3, 0);
    @(negedge clk);
    bus_req = 1'b1; bus_write = 1'b1; bus_addr = 12'h010; bus_wdata = 32'h0000_7000;
    evt_chain[3] = 1'b1;
    @(negedge clk);
    bus_req = 1'b0; bus_write = 1'b0; evt_chain = '0;
    rd(12'h010, d); chk(d, 32'h0000_4000, "R4 event beats clear");

    // R5 persistence, drop on disable, drop on clear
    clear_all();
    pulse(2, 1);
    wr(12'h000, 32'h0000_0200);
    repeat (4) @(negedge clk);
    chk(32'(irq), 1, "R5 irq held");
    wr(12'h000, 32'h0);
    @(negedge clk);
    chk(32'(irq), 0, "R5 irq drops on disable");
    wr(12'h000, 32'h0000_0200);
    @(negedge clk);
    chk(32'(irq), 1, "R5 irq back on enable");
    wr(12'h010, 32'h0000_0200);
    @(negedge clk);
    chk(32'(irq), 0, "R5 irq drops on clear");

    // R6 busy word, read-only
    chan_busy = 16'hA5C3;
    rd(12'h030, d); chk(d, 32'h0000_A5C3, "R6 busy word");
    wr(12'h030, 32'hFFFF_FFFF);
    rd(12'h030, d); chk(d, 32'h0000_A5C3, "R6 write ignored");

    // R7 unmapped offsets
    wr(12'h020, 32'hFFFF_FFFF);
    rd(12'h020, d); chk(d, 0, "R7 unmapped read");
    rd(12'h000, d); chk(d, 32'h0000_0200, "R7 unmapped write no effect");

    // R8 decode
    @(negedge clk);
    bus_addr = 12'h148 + 12'h100; #1;
    chk({30'b0, route_hit, own_hit}, 32'h2, "R8 window claim");
    chk(32'(route_idx), 5, "R8 window index");
    bus_addr = 12'h500; #1;
    chk({30'b0, route_hit, own_hit}, 32'h0, "R8 past last window");
    bus_addr = 12'h014; #1;
    chk({30'b0, route_hit, own_hit}, 32'h1, "R8 own register");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule